// File: doc/BRIEF.md
# Energy-Detect Link Sleep Controller

This block decides when a copper transceiver port may power down its main datapath because no partner is on the wire. It stays in a low-power state for a sleep interval, then spends a fixed wake window asking for link pulse bursts. These bursts alternate between two wire pairs and aim to rouse a partner that is itself asleep. If neither side sees energy, the port goes back to sleep. Any signal energy seen while asleep or waking moves the port to the normal (linked) state.

In the normal state with auto-negotiation on, a lost link starts a selectable timeout. If the timeout expires the port returns to low power. If the link comes back first, the timeout restarts. When the link speed is forced, the port stays in the normal state once it reaches it. Each sleep interval is nudged by a pseudo-random offset, so two sleeping ports cannot wake in lockstep forever. The offset comes from an LFSR that also takes in an external random bit.

All timing counts pulses of a periodic tick input. The parameter `SEC_TICKS` sets how many ticks make one second, so the whole schedule scales down for simulation.

Top module: `link_sleep_fsm`

## Requirements
- R1: While reset is asserted, `state_o` is 2'b00 (low power), `pwr_dn_o` is 1 and `burst_o` is 0.
- R2: The low-power state lasts (`sleep_sel_i`+1)·`SEC_TICKS` + d ticks, where d lies in [-`OFS_NEG`, +`OFS_POS`]. d is 0 for the first sleep after reset. d is redrawn on every later entry to low power. Timers advance only on cycles with `tick_i` high.
- R3: The partner-wake state (`state_o` = 2'b01) lasts `WAKE_SECS`·`SEC_TICKS` ticks and then returns to low power.
- R4: In partner-wake, a one-cycle burst request is raised on the entry tick and then every `BURST_TICKS` ticks. Requests alternate between pair A (`burst_o` = 2'b01) and pair B (2'b10), starting with A. No request is raised in any other state.
- R5: Signal energy seen in low power or partner-wake moves the block to normal (2'b10) at the next clock.
- R6: In normal with auto-negotiation enabled, link down for (`tmo_sel_i`+1)·`SEC_TICKS` ticks moves the block to low power. Link up clears the count.
- R7: In normal with auto-negotiation disabled, the block stays in normal whatever the link does.
- R8: With `en_i` low the block is in normal from the next clock and stays there.
- R9: `pwr_dn_o` is 1 in low power and partner-wake, and 0 in normal.
- R10: `state_o` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase strobe, one pulse per timer unit |
| en_i | input | 1 | Enables the power-saving mode |
| energy_i | input | 1 | Signal energy detected on the medium |
| link_i | input | 1 | Link status from the port |
| an_en_i | input | 1 | Auto-negotiation enabled |
| sleep_sel_i | input | 2 | Sleep length select, 1 to 4 seconds |
| tmo_sel_i | input | 2 | Link-loss timeout select, 1 to 4 seconds |
| rnd_i | input | 1 | External random bit folded into the LFSR |
| state_o | output | 2 | 00 low power, 01 partner-wake, 10 normal |
| pwr_dn_o | output | 1 | Power-down request for the main datapath |
| burst_o | output | 2 | Burst request, bit 0 pair A, bit 1 pair B |

## Verification
The bench builds the block with `SEC_TICKS`=10, `OFS_NEG`=3, `OFS_POS`=2 and `BURST_TICKS`=4, with the tick held high on most cycles. With these values every sleep select and timeout select completes within a few dozen cycles, so all four settings of each can be swept. The offset span of six values is small enough that repeated sleeps fall anywhere in the allowed window, and the wake window holds exactly five alternating bursts. Long hold phases with the tick held low, with auto-negotiation off and with the mode disabled then fit easily in the cycle budget.

// File: rtl/link_sleep_fsm.sv
module link_sleep_fsm #(
  parameter int SEC_TICKS   = 1000,
  parameter int OFS_NEG     = 80,
  parameter int OFS_POS     = 60,
  parameter int BURST_TICKS = 16,
  parameter int WAKE_SECS   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       energy_i,
  input  logic       link_i,
  input  logic       an_en_i,
  input  logic [1:0] sleep_sel_i,
  input  logic [1:0] tmo_sel_i,
  input  logic       rnd_i,
  output logic [1:0] state_o,
  output logic       pwr_dn_o,
  output logic [1:0] burst_o
);
  localparam int SPAN = OFS_NEG + OFS_POS + 1;
  localparam int CW   = $clog2(4 * SEC_TICKS + OFS_POS + 1) + 1;
  localparam int OW   = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam int BW   = (BURST_TICKS > 1) ? $clog2(BURST_TICKS) : 1;
  localparam logic [CW-1:0] SEC  = CW'(SEC_TICKS);
  localparam logic [CW-1:0] WAKE = CW'(WAKE_SECS * SEC_TICKS);

  typedef enum logic [1:0] {S_LP = 2'b00, S_WAKE = 2'b01, S_NORM = 2'b10} st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt;
  logic [OW-1:0] ofs;
  logic [BW-1:0] bcnt;
  logic          pair;
  logic [15:0]   lfsr;
  logic [CW-1:0] slp_lim, tmo_lim;
  logic [OW-1:0] ofs_next;
  logic          fire;

  assign slp_lim  = CW'(sleep_sel_i) * SEC + SEC + CW'(ofs) - CW'(OFS_NEG);
  assign tmo_lim  = CW'(tmo_sel_i) * SEC + SEC;
  assign ofs_next = OW'(lfsr % 16'(SPAN));
  assign fire     = (st == S_WAKE) && tick_i && (bcnt == '0);

  assign state_o  = st;
  assign pwr_dn_o = (st != S_NORM);
  assign burst_o  = fire ? (pair ? 2'b10 : 2'b01) : 2'b00;

  always_comb begin
    st_n = st;
    if (!en_i) st_n = S_NORM;
    else begin
      case (st)
        S_LP:   if (energy_i) st_n = S_NORM;
                else if (tick_i && cnt >= slp_lim - 1'b1) st_n = S_WAKE;
        S_WAKE: if (energy_i) st_n = S_NORM;
                else if (tick_i && cnt >= WAKE - 1'b1) st_n = S_LP;
        S_NORM: if (an_en_i && !link_i && tick_i && cnt >= tmo_lim - 1'b1) st_n = S_LP;
        default: st_n = S_LP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_LP;
      cnt  <= '0;
      ofs  <= OW'(OFS_NEG);
      bcnt <= '0;
      pair <= 1'b0;
      lfsr <= 16'hACE1;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10] ^ rnd_i};
      st   <= st_n;
      if (st_n != st) begin
        cnt  <= '0;
        bcnt <= '0;
        pair <= 1'b0;
        if (st_n == S_LP) ofs <= ofs_next;
      end else if (!en_i) begin
        cnt <= '0;
      end else if (st == S_NORM) begin
        if (!an_en_i || link_i) cnt <= '0;
        else if (tick_i) cnt <= cnt + 1'b1;
      end else if (tick_i) begin
        cnt <= cnt + 1'b1;
        if (st == S_WAKE) begin
          bcnt <= (bcnt == BW'(BURST_TICKS - 1)) ? '0 : bcnt + 1'b1;
          if (fire) pair <= ~pair;
        end
      end
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'b11); // R10
  AST_ENERGY_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && energy_i && state_o != 2'b10) |=> state_o == 2'b10); // R5
  AST_DISABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (state_o == 2'b10 && !pwr_dn_o)); // R8
  AST_FORCED_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !an_en_i && state_o == 2'b10) |=> state_o == 2'b10); // R7
  AST_LINK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && link_i && state_o == 2'b10) |=> state_o == 2'b10); // R6
  AST_NO_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i && !energy_i) |=> $stable(state_o)); // R2
  AST_BURST_IN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_o != 2'b00) |-> (pwr_dn_o && state_o == 2'b01)); // R4
endmodule

// File: tb/sim_link_sleep_fsm.sv
module sim_link_sleep_fsm;
  localparam int S = 10, NEG = 3, POS = 2, BT = 4, WS = 2;
  logic clk = 0, rst_n = 0, tick = 1, en = 1, energy = 0, link = 0, an_en = 1, rnd = 0;
  logic [1:0] ssel = 0, tsel = 0;
  logic [1:0] state, burst;
  logic pd;
  int checks = 0, errors = 0;

  link_sleep_fsm #(.SEC_TICKS(S), .OFS_NEG(NEG), .OFS_POS(POS), .BURST_TICKS(BT), .WAKE_SECS(WS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(en), .energy_i(energy), .link_i(link),
    .an_en_i(an_en), .sleep_sel_i(ssel), .tmo_sel_i(tsel), .rnd_i(rnd),
    .state_o(state), .pwr_dn_o(pd), .burst_o(burst));

  always #5 clk = ~clk;
  always @(posedge clk) rnd <= $urandom_range(0, 1);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_state(input logic [1:0] s, output int dur, output int nb,
                           output bit alt_ok, output bit side_ok);
    dur = 0; nb = 0; alt_ok = 1; side_ok = 1;
    while (state == s && dur < 1000) begin
      if (pd != (s != 2'b10)) side_ok = 0;
      if (burst != 2'b00) begin
        if (s != 2'b01) side_ok = 0;
        if (burst != ((nb % 2 == 0) ? 2'b01 : 2'b10)) alt_ok = 0;
        nb++;
      end
      dur++;
      @(negedge clk);
    end
    if (state == 2'b11) side_ok = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    step(3);
    chk(state == 2'b00, "R1 state in reset", state, 0);
    chk(pd == 1'b1 && burst == 2'b00, "R1/R9 outputs in reset", {pd, burst}, 4);
    rst_n = 1;
  endtask

  task automatic pulse_energy();
    energy = 1; step(1); energy = 0;
  endtask

  initial begin
    int d, nb, lo, hi;
    bit a, sd;
    step(1);
    for (int sel = 0; sel < 4; sel++) begin
      ssel = 2'(sel);
      do_reset();
      run_state(2'b00, d, nb, a, sd);
      chk(d == (sel + 1) * S, "R2 first sleep length", d, (sel + 1) * S);
      chk(sd, "R9/R10 low-power outputs", sd, 1);
      for (int k = 0; k < 3; k++) begin
        run_state(2'b01, d, nb, a, sd);
        chk(d == WS * S, "R3 wake length", d, WS * S);
        chk(nb == (WS * S + BT - 1) / BT, "R4 burst count", nb, (WS * S + BT - 1) / BT);
        chk(a && sd, "R4/R9 burst alternation", {a, sd}, 3);
        run_state(2'b00, d, nb, a, sd);
        lo = (sel + 1) * S - NEG; hi = (sel + 1) * S + POS;
        chk(d >= lo && d <= hi && nb == 0, "R2 randomized sleep length", d, lo);
      end
    end

    for (int t = 0; t < 4; t++) begin
      tsel = 2'(t); link = 0; an_en = 1;
      step(2);
      pulse_energy();
      chk(state == 2'b10 && pd == 0, "R5/R9 energy in low power", state, 2);
      run_state(2'b10, d, nb, a, sd);
      chk(d == (t + 1) * S && sd, "R6 link-loss timeout", d, (t + 1) * S);
    end

    tsel = 1;
    pulse_energy();
    step(2 * S - 2);
    chk(state == 2'b10, "R6 before expiry", state, 2);
    link = 1; step(5);
    chk(state == 2'b10, "R6 link up holds", state, 2);
    link = 0;
    run_state(2'b10, d, nb, a, sd);
    chk(d == 2 * S, "R6 timer restarts", d, 2 * S);

    an_en = 0;
    pulse_energy();
    step(6 * S);
    chk(state == 2'b10, "R7 forced link stays normal", state, 2);
    an_en = 1;

    ssel = 0; tsel = 0;
    do_reset();
    step(3);
    en = 0; step(1);
    chk(state == 2'b10 && pd == 0, "R8 disable forces normal", state, 2);
    step(100);
    chk(state == 2'b10 && burst == 0, "R8 disable holds", state, 2);
    en = 1;
    run_state(2'b10, d, nb, a, sd);
    chk(d == S, "R6 timeout after re-enable", d, S);

    do_reset();
    run_state(2'b00, d, nb, a, sd);
    step(3);
    chk(state == 2'b01, "R3 in wake", state, 1);
    pulse_energy();
    chk(state == 2'b10, "R5 energy in wake", state, 2);

    ssel = 2;
    tick = 0;
    do_reset();
    step(300);
    chk(state == 2'b00 && burst == 0, "R2 no tick freezes sleep", state, 0);
    tick = 1;
    run_state(2'b00, d, nb, a, sd);
    chk(d == 3 * S, "R2 sleep resumes on tick", d, 3 * S);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule